// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

The block puts up to four 32-bit audio channel words onto one serial data line, one slot after another, inside a time-division-multiplexed frame. It runs on the bit clock. A frame starts on a rising edge of frame sync. In slave mode that edge comes in on `fs_in`. In master mode the block makes its own frame sync from a programmed frame length. Channel words are sent most significant bit first. The words of the enabled channels are packed into consecutive slots in ascending channel order. A programmable slot offset delays the first slot by 0 to 31 bit periods.

A new set of samples is written into a pending register with `smp_valid`. At each frame start the pending words go into a shadow register, and `smp_taken` pulses one cycle later, so writes made during a frame only show up in the next one. A state machine tracks the frame and has four states. `ST_IDLE` waits for the first frame after reset. `ST_OFFS` counts out the offset. `ST_SEND` shifts out slot bits. `ST_FILL` drives zeros until the next frame.

The transitions are these. Frame start moves every state to `ST_SEND` when the offset is 0 or 1, to `ST_OFFS` when the offset is 2 or more, and to `ST_FILL` when no channel is enabled. `ST_OFFS` moves to `ST_SEND` when its count reaches zero. `ST_SEND` moves on to the next slot when the last bit of a word goes out, and to `ST_FILL` after the last bit of the last enabled slot. `ST_IDLE` and `ST_FILL` hold until a frame start. In slave mode, a frame start that arrives in `ST_OFFS` or `ST_SEND` aborts the frame, restarts at slot 0 and sets a sticky early-sync flag.

Top module: `tdm_tx`

## Requirements
- R1: In slave mode a frame starts only in the bit period where `fs_in` is high after having been low in the previous period. Holding `fs_in` high for more periods does not restart the frame.
- R2: With slot offset O, the MSB of slot 0 is on `sdout` in the bit period O periods after the frame-start period. With O = 0 it is on `sdout` in the frame-start period itself.
- R3: During the O offset periods before slot 0, `sdout` is 0.
- R4: Slot k carries the word of the k-th enabled channel, counting up from channel 0. Channel c sits at `smp_data[32c+31:32c]` and is enabled by `ch_mask[c]`. Each word is 32 bits, MSB first, and slots follow each other with no gap.
- R5: After the last bit of the last enabled slot, and until the next frame start, `sdout` is 0. With no channel enabled the whole frame is 0.
- R6: The words sent in a frame are those written by the last `smp_valid` before the frame-start edge. Writes during the frame do not change it. `smp_taken` is high for exactly the one cycle after each frame-start period.
- R7: `cfg_err` is 1 exactly when `frm_len` is less than 32 times the number of set bits in `ch_mask`.
- R8: In slave mode, a frame start during the offset or a slot restarts the frame at slot 0 with the current pending words and sets `early_err`. `early_err` then stays at 1 until reset.
- R9: In master mode, `fs_out` is high for one period at the start of every `frm_len`-period frame. The first frame starts in the first period after reset release, and `fs_in` is ignored.
- R10: After reset in slave mode, `sdout`, `fs_out`, `smp_taken` and `early_err` are 0, and `sdout` stays 0 until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate frame sync; 0: take it from `fs_in` |
| fs_in | input | 1 | Frame sync input for slave mode |
| frm_len | input | 10 | Bit periods per frame (master), and the length checked for `cfg_err` |
| ch_mask | input | 4 | Channel enable mask |
| slot_ofs | input | 5 | Bit periods between frame start and slot 0's MSB |
| smp_data | input | 128 | Four 32-bit channel words, channel 0 in the low bits |
| smp_valid | input | 1 | Writes `smp_data` into the pending register |
| sdout | output | 1 | Serial data |
| fs_out | output | 1 | Generated frame sync (master mode) |
| smp_taken | output | 1 | Pending words were moved into the frame shadow |
| cfg_err | output | 1 | Frame too short for the enabled channels |
| early_err | output | 1 | Sticky: early frame sync in slave mode |

## Verification
The serial bit for frame position q is due in the same bit period as position q. Position 0 is the frame-start period, where the offset-0 MSB is combinational. Every later position comes from registered state one rising edge later. The bench drives `fs_in` and data just after each falling edge and samples 1 ns later. This way it reads each position in the period it belongs to, for every position of every frame. `smp_taken` is checked high at position 1 and low at position 2. `fs_out` and the master-mode data are checked against a period count taken from reset release. `cfg_err` is combinational and is read 1 ns after its inputs change.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OFFS,
        ST_SEND,
        ST_FILL
    } tx_state_t;
endpackage

// File: rtl/tdm_slot_order.sv
module tdm_slot_order #(
    parameter int NCH  = 4,
    parameter int WORD = 32,
    localparam int CNTW = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]      mask,
    input  logic [NCH*WORD-1:0] words,
    output logic [NCH*WORD-1:0] packed_words,
    output logic [CNTW-1:0]     active
);
    always_comb begin
        packed_words = '0;
        active       = '0;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                packed_words[int'(active)*WORD +: WORD] = words[c*WORD +: WORD];
                active = active + CNTW'(1);
            end
        end
    end
endmodule

// File: rtl/tdm_frame_start.sv
module tdm_frame_start #(
    parameter int FLW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           master,
    input  logic           fs_in,
    input  logic [FLW-1:0] frm_len,
    output logic           fstart,
    output logic           fs_out
);
    logic           fs_q;
    logic [FLW-1:0] mcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
            mcnt <= '0;
        end else begin
            fs_q <= fs_in;
            if (!master || (32'(mcnt) + 32'd1 >= 32'(frm_len)))
                mcnt <= '0;
            else
                mcnt <= mcnt + FLW'(1);
        end
    end

    always_comb begin
        fs_out = rst_n && master && (mcnt == '0);
        fstart = master ? fs_out : (fs_in && !fs_q);
    end

    // R9: generated sync lasts a single bit period
    a_r9_single_sync: assert property (@(posedge clk) disable iff (!rst_n)
        master && fs_out && (frm_len > FLW'(1)) && $stable(frm_len)
        |=> !fs_out || !master);

    // R1: a level held high never produces a second start in slave mode
    a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !master && fs_in |=> !(fstart && !master && $past(!master)));
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int WORD = 32,
    parameter int FLW  = 10,
    parameter int OFSW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master,
    input  logic                fs_in,
    input  logic [FLW-1:0]      frm_len,
    input  logic [NCH-1:0]      ch_mask,
    input  logic [OFSW-1:0]     slot_ofs,
    input  logic [NCH*WORD-1:0] smp_data,
    input  logic                smp_valid,
    output logic                sdout,
    output logic                fs_out,
    output logic                smp_taken,
    output logic                cfg_err,
    output logic                early_err
);
    localparam int CNTW = $clog2(NCH + 1);
    localparam int BW   = $clog2(WORD);
    localparam int IDXW = $clog2(NCH * WORD);

    tx_state_t           state, state_n;
    logic [CNTW-1:0]     slot, slot_n;
    logic [BW-1:0]       bitn, bitn_n;
    logic [OFSW-1:0]     ocnt, ocnt_n;
    logic [CNTW-1:0]     nact_q, nact_live;
    logic [NCH*WORD-1:0] pend, shadow, ord_live;
    logic                fstart;

    tdm_frame_start #(.FLW(FLW)) u_fstart (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (master),
        .fs_in   (fs_in),
        .frm_len (frm_len),
        .fstart  (fstart),
        .fs_out  (fs_out)
    );

    tdm_slot_order #(.NCH(NCH), .WORD(WORD)) u_order (
        .mask         (ch_mask),
        .words        (pend),
        .packed_words (ord_live),
        .active       (nact_live)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        slot_n  = slot;
        bitn_n  = bitn;
        ocnt_n  = ocnt;
        if (fstart) begin
            slot_n = '0;
            if (nact_live == '0) begin
                state_n = ST_FILL;
            end else if (slot_ofs == '0) begin
                state_n = ST_SEND;
                bitn_n  = BW'(WORD - 2);
            end else if (slot_ofs == OFSW'(1)) begin
                state_n = ST_SEND;
                bitn_n  = BW'(WORD - 1);
            end else begin
                state_n = ST_OFFS;
                ocnt_n  = slot_ofs - OFSW'(2);
            end
        end else begin
            unique case (state)
                ST_IDLE, ST_FILL: ;
                ST_OFFS: begin
                    if (ocnt == '0) begin
                        state_n = ST_SEND;
                        bitn_n  = BW'(WORD - 1);
                    end else begin
                        ocnt_n = ocnt - OFSW'(1);
                    end
                end
                ST_SEND: begin
                    if (bitn == '0) begin
                        if (slot == nact_q - CNTW'(1)) begin
                            state_n = ST_FILL;
                        end else begin
                            slot_n = slot + CNTW'(1);
                            bitn_n = BW'(WORD - 1);
                        end
                    end else begin
                        bitn_n = bitn - BW'(1);
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            slot      <= '0;
            bitn      <= '0;
            ocnt      <= '0;
            nact_q    <= '0;
            pend      <= '0;
            shadow    <= '0;
            smp_taken <= 1'b0;
            early_err <= 1'b0;
        end else begin
            state     <= state_n;
            slot      <= slot_n;
            bitn      <= bitn_n;
            ocnt      <= ocnt_n;
            smp_taken <= fstart;
            if (smp_valid) pend <= smp_data;
            if (fstart) begin
                shadow <= ord_live;
                nact_q <= nact_live;
                if (!master && (state == ST_OFFS || state == ST_SEND))
                    early_err <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        if (fstart)
            sdout = (slot_ofs == '0) && (nact_live != '0) && ord_live[WORD-1];
        else if (state == ST_SEND)
            sdout = shadow[IDXW'(slot) * IDXW'(WORD) + IDXW'(bitn)];
        else
            sdout = 1'b0;
        cfg_err = 32'(frm_len) < 32'(nact_live) * 32'(WORD);
    end

    // R3: zeros while the offset is counted out
    a_r3_offs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFFS) && !fstart |-> !sdout);

    // R5: zeros after the last slot
    a_r5_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) && !fstart |-> !sdout);

    // R6: consumption strobe follows every frame start
    a_r6_taken: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |=> smp_taken);

    // R8: early sync flag is raised and then held
    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        !master && fstart && (state == ST_SEND) |=> early_err);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        early_err |=> early_err);

    // R4: sending never runs past the slots captured for the frame
    a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (slot < nact_q));
endmodule

// File: tb/tdm_tx_tb.sv
module tdm_tx_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         master = 1'b0;
    logic         fs_in = 1'b0;
    logic [9:0]   frm_len = 10'd160;
    logic [3:0]   ch_mask = 4'h0;
    logic [4:0]   slot_ofs = 5'd0;
    logic [127:0] smp_data = '0;
    logic         smp_valid = 1'b0;
    logic         sdout, fs_out, smp_taken, cfg_err, early_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_tx u_dut (
        .clk(clk), .rst_n(rst_n), .master(master), .fs_in(fs_in),
        .frm_len(frm_len), .ch_mask(ch_mask), .slot_ofs(slot_ofs),
        .smp_data(smp_data), .smp_valid(smp_valid), .sdout(sdout),
        .fs_out(fs_out), .smp_taken(smp_taken), .cfg_err(cfg_err),
        .early_err(early_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] mkdata(input int s);
        logic [127:0] d;
        for (int c = 0; c < 4; c++)
            d[c*32 +: 32] = (32'(s) * 32'h2545F491 + 32'(c) * 32'h9E3779B9) ^ 32'hA5C3_0F96;
        return d;
    endfunction

    // expected serial bit at frame position q
    function automatic logic exp_bit(input logic [3:0] m, input int o,
                                     input logic [127:0] d, input int q);
        int qq, k, n;
        if (q < o) return 1'b0;
        qq = q - o;
        k  = qq / 32;
        n  = 0;
        for (int c = 0; c < 4; c++) begin
            if (m[c]) begin
                if (n == k) return d[c*32 + 31 - (qq % 32)];
                n++;
            end
        end
        return 1'b0;
    endfunction

    function automatic string tag_for(input logic [3:0] m, input int o, input int q, input int fsw);
        if (q == o && m != 4'h0) return "R2";
        if (q > 0 && q < fsw) return "R1";
        if (q < o) return "R3";
        if (q - o < 32 * $countones(m)) return "R4";
        return "R5";
    endfunction

    task automatic run_frame(input logic [3:0] m, input int o, input int flen,
                             input int fsw, input int early_at,
                             input logic [127:0] cur, input logic [127:0] nxt);
        int q;
        logic [127:0] d;
        for (int p = 0; p < flen; p++) begin
            @(negedge clk);
            ch_mask   = m;
            slot_ofs  = 5'(o);
            fs_in     = (p < fsw) || (p == early_at);
            smp_valid = (p == 10);
            if (p == 10) smp_data = nxt;
            #1;
            q = (p >= early_at) ? p - early_at : p;
            d = (p >= early_at) ? nxt : cur;
            chk(tag_for(m, o, q, fsw), 32'(sdout), 32'(exp_bit(m, o, d, q)));
            if (q == 1) chk("R6 taken", 32'(smp_taken), 32'd1);
            if (q == 2) chk("R6 taken", 32'(smp_taken), 32'd0);
        end
    endtask

    initial begin
        int s;
        logic [127:0] dm;
        int offs [5] = '{0, 1, 2, 17, 31};

        // R10: reset state
        #1;
        chk("R10 sdout", 32'(sdout), 32'd0);
        chk("R10 fs_out", 32'(fs_out), 32'd0);
        chk("R10 taken", 32'(smp_taken), 32'd0);
        chk("R10 early", 32'(early_err), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ch_mask = 4'hF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R10 idle", 32'(sdout), 32'd0);
        end
        @(negedge clk);
        smp_data = mkdata(0); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;

        // R1..R6: sweep masks and offsets in slave mode
        s = 0;
        for (int m = 0; m < 16; m++) begin
            for (int oi = 0; oi < 5; oi++) begin
                run_frame(4'(m), offs[oi], 160, (m % 3) + 1, 9999, mkdata(s), mkdata(s + 1));
                s++;
            end
        end

        // R8: early sync
        chk("R8 no flag", 32'(early_err), 32'd0);
        run_frame(4'hF, 0, 210, 1, 50, mkdata(s), mkdata(s + 1));
        s++;
        chk("R8 flag", 32'(early_err), 32'd1);
        run_frame(4'h5, 3, 160, 2, 9999, mkdata(s), mkdata(s + 1));
        s++;
        chk("R8 sticky", 32'(early_err), 32'd1);

        // R7: configuration check
        @(negedge clk);
        ch_mask = 4'hF; frm_len = 10'd127; #1;
        chk("R7 short", 32'(cfg_err), 32'd1);
        frm_len = 10'd128; #1;
        chk("R7 exact", 32'(cfg_err), 32'd0);
        ch_mask = 4'hB; frm_len = 10'd95; #1;
        chk("R7 three short", 32'(cfg_err), 32'd1);
        frm_len = 10'd96; #1;
        chk("R7 three ok", 32'(cfg_err), 32'd0);
        ch_mask = 4'h0; frm_len = 10'd0; #1;
        chk("R7 none", 32'(cfg_err), 32'd0);

        // R9: master mode
        @(negedge clk);
        rst_n = 1'b0; master = 1'b1; frm_len = 10'd100;
        ch_mask = 4'hD; slot_ofs = 5'd3; fs_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        dm = mkdata(77);
        for (int p = 0; p < 300; p++) begin
            if (p != 0) @(negedge clk);
            fs_in = p[0] ^ p[2];
            smp_valid = (p == 0);
            smp_data = dm;
            #1;
            chk("R9 fs_out", 32'(fs_out), 32'((p % 100) == 0));
            chk("R9 sdout", 32'(sdout),
                32'(exp_bit(4'hD, 3, (p < 100) ? 128'd0 : dm, p % 100)));
        end
        smp_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule